// File: doc/BRIEF.md
# Bubble-Tolerant Thermometer Encoder

This block turns the comparator bank of an N-bit flash converter into a binary sample. The 2^N-1 comparator outputs are registered once so that a metastable comparator has a full cycle to settle. A window of three adjacent bits at each position then marks the single place where the thermometer code steps from ones to zeros. Each output bit is the OR of the marker positions whose code has that bit set. The code is held in an output register, and a valid flag travels through the pipeline beside it.

A parameter selects Gray mode. In that mode the OR trees build a Gray code, and a prefix-XOR stage converts it back to binary before the output register. A comparator that is caught between states then disturbs at most one Gray bit. The mode changes the result only when more than one marker is active.

Top module: `therm_encoder`

## Requirements
- R1: For a clean thermometer input with k ones in bits 0..k-1 (k from 0 to 2^N-1), code_o equals k in binary. An all-zero input gives 0 and an all-ones input gives 2^N-1.
- R2: code_o reflects the comparator vector sampled two rising edges earlier. A new vector is accepted on every cycle.
- R3: A synchronous active-high rst clears code_o to 0 and valid_o to 0 at the next edge. After rst falls, valid_o rises at the second rising edge and stays high until the next reset.
- R4: A single isolated 1 lying above the top of the thermometer run, with a 0 directly below it, is ignored. Example for N=4: input 0x021F gives 5.
- R5: The marker for count k (1..2^N-1) is active when bits k-2 and k-1 are 1 and bit k is 0. Bit -1 is taken as 1 and bit 2^N-1 as 0. When several markers are active, their codes are ORed. Example: input 0x00F7 (zero bubble at bit 3) gives 3|8 = 11.
- R6: With GRAY=1, the Gray codes of the active markers are ORed and the result is converted to binary. Clean inputs give the same codes as R1. Input 0x061F, which activates the markers for 5 and 11, gives 15 with GRAY=0 and 10 with GRAY=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| comp_i | input | 2^N-1 | Comparator outputs, bit 0 is the lowest threshold |
| code_o | output | N | Encoded binary sample |
| valid_o | output | 1 | code_o holds a sample taken since the last reset |

## Verification
The window correction and the OR merge act in the same cycle when one input produces both a suppressed position and several surviving markers. A two-bit sparkle above the run does this: its lower bit is removed by the window, while its upper bit survives as a second marker. The bench drives 0x061F into a binary instance and a Gray instance side by side and expects 15 and 10, values worked out by hand from R5 and R6. A reset pulse is also driven while samples are in flight, to check that both valid_o and code_o are cleared at that edge.

// File: rtl/therm_encoder.sv
module therm_encoder #(
  parameter int N    = 4,
  parameter bit GRAY = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [(1<<N)-2:0]  comp_i,
  output logic [N-1:0]       code_o,
  output logic               valid_o
);
  localparam int M = (1 << N) - 1;

  function automatic logic [N-1:0] code_of(input int k);
    logic [N-1:0] v;
    v = k[N-1:0];
    return GRAY ? (v ^ (v >> 1)) : v;
  endfunction

  logic [M-1:0] t_q;
  logic         v_q;
  logic [M+1:0] ext;
  logic [M:1]   mark;
  logic [N-1:0] enc, bin;

  always_ff @(posedge clk) begin
    if (rst) begin
      t_q     <= '0;
      v_q     <= 1'b0;
      code_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      t_q     <= comp_i;
      v_q     <= 1'b1;
      code_o  <= bin;
      valid_o <= v_q;
    end
  end

  assign ext = {1'b0, t_q, 1'b1};

  for (genvar k = 1; k <= M; k++) begin : g_win
    assign mark[k] = ext[k-1] & ext[k] & ~ext[k+1];
  end

  for (genvar b = 0; b < N; b++) begin : g_tree
    logic [M:1] sel;
    for (genvar k = 1; k <= M; k++) begin : g_leaf
      localparam logic [N-1:0] CK = code_of(k);
      assign sel[k] = mark[k] & CK[b];
    end
    assign enc[b] = |sel;
  end

  if (GRAY) begin : g_gray
    assign bin[N-1] = enc[N-1];
    for (genvar b = N - 2; b >= 0; b--) begin : g_x
      assign bin[b] = bin[b+1] ^ enc[b];
    end
  end else begin : g_bin
    assign bin = enc;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid_o && code_o == '0)); // R3
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> valid_o); // R3
  AST_ONEHOT_MARK: assert property (@(posedge clk) disable iff (rst)
    ((t_q & (t_q + 1'b1)) == '0) |-> $onehot0(mark)); // R5
  AST_ZERO_SCALE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(t_q == '0)) |-> code_o == '0); // R1
  AST_FULL_SCALE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(&t_q)) |-> code_o == N'(M)); // R1
endmodule

// File: tb/test_therm_encoder.sv
module test_therm_encoder;
  localparam int N = 4;
  localparam int M = (1 << N) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [M-1:0] comp = '0;
  logic [N-1:0] code_b, code_g;
  logic         valid_b, valid_g;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  therm_encoder #(.N(N), .GRAY(1'b0)) i_therm_encoder (
    .clk(clk), .rst(rst), .comp_i(comp), .code_o(code_b), .valid_o(valid_b));
  therm_encoder #(.N(N), .GRAY(1'b1)) i_therm_encoder_gray (
    .clk(clk), .rst(rst), .comp_i(comp), .code_o(code_g), .valid_o(valid_g));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [M-1:0] therm(input int k);
    logic [M-1:0] v = '0;
    for (int i = 0; i < M; i++) if (i < k) v[i] = 1'b1;
    return v;
  endfunction

  task automatic apply(input logic [M-1:0] v);
    @(negedge clk) comp = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    comp = '1;
    repeat (3) @(negedge clk);
    check("R3 reset valid", valid_b, 0);
    check("R3 reset code", code_b, 0);
    check("R3 reset gray valid", valid_g, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R3 valid low after one edge", valid_b, 0);
    @(negedge clk);
    check("R3 valid high after two edges", valid_b, 1);
    check("R2 first sample", code_b, M);
  endtask

  task automatic test_clean();
    for (int k = 0; k <= M; k++) begin
      apply(therm(k));
      check("R1 clean binary", code_b, k);
      check("R6 clean gray", code_g, k);
      check("R3 valid stays high", valid_b, 1);
    end
  endtask

  task automatic test_sparkle();
    apply(15'h021F);
    check("R4 sparkle binary", code_b, 5);
    check("R4 sparkle gray", code_g, 5);
  endtask

  task automatic test_bubble();
    apply(15'h00F7);
    check("R5 bubble OR binary", code_b, 11);
    check("R5 bubble OR gray", code_g, 11);
  endtask

  task automatic test_double_marker();
    apply(15'h061F);
    check("R5 two markers binary", code_b, 15);
    check("R6 two markers gray", code_g, 10);
  endtask

  task automatic test_stream();
    int hist[$];
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i >= 2) check("R2 streaming latency", code_b, hist[i-2]);
      hist.push_back((i * 7) % (M + 1));
      comp = therm(hist[i]);
    end
  endtask

  task automatic test_mid_reset();
    apply(therm(9));
    @(negedge clk) comp = therm(3);
    rst = 1'b1;
    @(negedge clk);
    check("R3 mid reset valid", valid_b, 0);
    check("R3 mid reset code", code_b, 0);
    rst = 1'b0;
    comp = therm(6);
    @(negedge clk);
    @(negedge clk);
    check("R3 valid back after reset", valid_b, 1);
    check("R2 sample after reset", code_b, 6);
  endtask

  initial begin
    test_reset();
    test_clean();
    test_sparkle();
    test_bubble();
    test_double_marker();
    test_stream();
    test_mid_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule